// File: doc/BRIEF.md
# Keyed Control Register Unlock

This block holds one byte-wide control register that software may change only after it opens a guard. The guard is a separate key register on the same simple synchronous register bus: the two magic bytes 0x87 and 0x59 must be stored into it one after the other. Once the guard is open, writes to the control register take effect. Any key write other than those two bytes shuts the guard again.

The stored control bits drive three live outputs: an auxiliary-RAM enable, a flash programming enable and a boot-select flag. A write that sets bits 7, 1 and 0 together is not stored. Instead it raises a software-reset request for a single cycle. That same pulse wipes the control register and relocks the guard. When the control register is read, bit 7 shows a boot-mode strap pin rather than stored state.

Top module: `cfg_key_guard`

## Requirements
- R1: After a hardware reset, and again after reset is released mid-run, the control bits read as 0, every derived output is low and the guard is closed.
- R2: While the guard is closed, a write to the control address leaves the control register unchanged.
- R3: A key write of 0x87 followed by a key write of 0x59 opens the guard, and control writes then land and read back on the next cycle.
- R4: A key write of any byte other than 0x87 or 0x59 closes the guard, including one placed between 0x87 and 0x59.
- R5: A key write of 0x59 that does not follow 0x87 does not open the guard.
- R6: Bus writes to other addresses do not disturb a pending key sequence, and a repeated 0x87 still counts as the first key.
- R7: aux_ram_en follows control bit 4, prog_en follows control bit 0 and boot_sel follows control bit 1.
- R8: An accepted control write with bits 7, 1 and 0 all set raises sw_rst_pulse for exactly one cycle, starting the cycle after the write, and does not store its data. The same write made while the guard is closed raises no pulse.
- R9: The cycle after sw_rst_pulse, the control register is 0 and the guard is closed.
- R10: A control read returns boot_strap in bit 7 and 0 in bits 6 and 5. The remaining bits 4 to 0 are the stored control bits.
- R11: Reads of the key address or of any unmapped address return 0.
- R12: A control write with bit 7 set but without both bits 1 and 0 set is stored normally (bits 4 to 0) and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| boot_strap | input | 1 | Boot-mode indicator, read back as control bit 7 |
| aux_ram_en | output | 1 | Auxiliary RAM enable (control bit 4) |
| prog_en | output | 1 | Flash programming enable (control bit 0) |
| boot_sel | output | 1 | Boot-select flag (control bit 1) |
| sw_rst_pulse | output | 1 | Single-cycle software-reset request |

## Verification
The assertions take it for granted that each bus write lasts a single cycle and that boot_strap only moves while no read of the control address is being checked. They also assume the key and control addresses differ, so that one write never counts as both. The stimulus drives every write as a one-cycle strobe set up away from the clock edge. It keeps the strap steady across each read window and uses only the two default addresses plus one unmapped address.

// File: rtl/cfg_key_pkg.sv
package cfg_key_pkg;

    localparam int DATA_W = 8;
    localparam int CTRL_KEEP_W = 5;

    localparam logic [DATA_W-1:0] KEY_OPEN_A = 8'h87;
    localparam logic [DATA_W-1:0] KEY_OPEN_B = 8'h59;

    localparam int BIT_PROG  = 0;
    localparam int BIT_BSEL  = 1;
    localparam int BIT_AUX   = 4;
    localparam int BIT_SWRST = 7;

    typedef enum logic {
        PH_IDLE,
        PH_HALF
    } key_phase_e;

    typedef struct packed {
        logic aux;
        logic spare3;
        logic spare2;
        logic bsel;
        logic prog;
    } ctrl_bits_t;

    function automatic logic is_reset_combo(input logic [DATA_W-1:0] d);
        return d[BIT_SWRST] & d[BIT_BSEL] & d[BIT_PROG];
    endfunction

    function automatic ctrl_bits_t to_ctrl(input logic [DATA_W-1:0] d);
        return ctrl_bits_t'(d[CTRL_KEEP_W-1:0]);
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_view(input ctrl_bits_t c, input logic strap);
        logic [DATA_W-1:0] v;
        v = '0;
        v[CTRL_KEEP_W-1:0] = c;
        v[BIT_SWRST] = strap;
        return v;
    endfunction

endpackage

// File: rtl/ckg_key_seq.sv
module ckg_key_seq
    import cfg_key_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    output logic              open
);

    key_phase_e phase_q;
    logic       open_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= PH_IDLE;
            open_q  <= 1'b0;
        end else if (key_wr) begin
            if (key_data == KEY_OPEN_A) begin
                phase_q <= PH_HALF;
            end else if (key_data == KEY_OPEN_B) begin
                phase_q <= PH_IDLE;
                if (phase_q == PH_HALF) begin
                    open_q <= 1'b1;
                end
            end else begin
                phase_q <= PH_IDLE;
                open_q  <= 1'b0;
            end
        end
    end

    assign open = open_q;

endmodule

// File: rtl/ckg_ctrl_reg.sv
module ckg_ctrl_reg
    import cfg_key_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_bits_t        ctrl,
    output logic              rst_req
);

    ctrl_bits_t ctrl_q;
    logic       req_q;
    logic       combo;

    assign combo = is_reset_combo(wdata);

    always_ff @(posedge clk) begin
        if (rst || req_q) begin
            ctrl_q <= '0;
            req_q  <= 1'b0;
        end else begin
            req_q <= ctrl_wr && combo;
            if (ctrl_wr && !combo) begin
                ctrl_q <= to_ctrl(wdata);
            end
        end
    end

    assign ctrl    = ctrl_q;
    assign rst_req = req_q;

endmodule

// File: rtl/ckg_rd_mux.sv
module ckg_rd_mux
    import cfg_key_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h17
) (
    input  logic [ADDR_W-1:0] addr,
    input  ctrl_bits_t        ctrl,
    input  logic              strap,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        if (addr == CTRL_ADDR) begin
            rdata = ctrl_view(ctrl, strap);
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/cfg_key_guard.sv
module cfg_key_guard
    import cfg_key_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'h16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              boot_strap,
    output logic              aux_ram_en,
    output logic              prog_en,
    output logic              boot_sel,
    output logic              sw_rst_pulse
);

    logic       key_hit;
    logic       ctrl_hit;
    logic       guard_open;
    logic       req;
    ctrl_bits_t ctrl;

    assign key_hit  = bus_we && (bus_addr == KEY_ADDR);
    assign ctrl_hit = bus_we && (bus_addr == CTRL_ADDR) && guard_open;

    ckg_key_seq u_key (
        .clk      (clk),
        .rst      (rst),
        .clr      (req),
        .key_wr   (key_hit),
        .key_data (bus_wdata),
        .open     (guard_open)
    );

    ckg_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ctrl_wr (ctrl_hit),
        .wdata   (bus_wdata),
        .ctrl    (ctrl),
        .rst_req (req)
    );

    ckg_rd_mux #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_rd (
        .addr  (bus_addr),
        .ctrl  (ctrl),
        .strap (boot_strap),
        .rdata (bus_rdata)
    );

    assign aux_ram_en   = ctrl.aux;
    assign prog_en      = ctrl.prog;
    assign boot_sel     = ctrl.bsel;
    assign sw_rst_pulse = req;

endmodule

// File: rtl/cfg_key_guard_chk.sv
module cfg_key_guard_chk
    import cfg_key_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'h16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h17
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              boot_strap,
    input logic              aux_ram_en,
    input logic              prog_en,
    input logic              boot_sel,
    input logic              sw_rst_pulse
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !aux_ram_en && !prog_en && !boot_sel && !sw_rst_pulse);

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        sw_rst_pulse |=> !sw_rst_pulse);

    // R8
    pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_rst_pulse) |-> $past(bus_we && bus_addr == CTRL_ADDR
            && bus_wdata[BIT_SWRST] && bus_wdata[BIT_BSEL] && bus_wdata[BIT_PROG]));

    // R9
    pulse_clears_chk: assert property (@(posedge clk) disable iff (rst)
        sw_rst_pulse |=> !aux_ram_en && !prog_en && !boot_sel);

    // R2
    prog_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(prog_en) |-> $past(bus_we && bus_addr == CTRL_ADDR) || $past(sw_rst_pulse));

    // R2
    aux_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(aux_ram_en) |-> $past(bus_we && bus_addr == CTRL_ADDR) || $past(sw_rst_pulse));

    // R10
    strap_view_chk: assert property (@(posedge clk) disable iff (rst)
        bus_addr == CTRL_ADDR |-> bus_rdata[BIT_SWRST] == boot_strap && bus_rdata[6:5] == 2'b00);

    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_addr != CTRL_ADDR |-> bus_rdata == '0);

endmodule

bind cfg_key_guard cfg_key_guard_chk #(
    .ADDR_W    (ADDR_W),
    .KEY_ADDR  (KEY_ADDR),
    .CTRL_ADDR (CTRL_ADDR)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .boot_strap   (boot_strap),
    .aux_ram_en   (aux_ram_en),
    .prog_en      (prog_en),
    .boot_sel     (boot_sel),
    .sw_rst_pulse (sw_rst_pulse)
);

// File: tb/cfg_key_guard_tb.sv
`timescale 1ns/1ps
module cfg_key_guard_tb;

    localparam logic [7:0] KA = 8'h16;
    localparam logic [7:0] CA = 8'h17;
    localparam logic [7:0] UA = 8'h20;
    localparam logic [3:0] OP_WR = 4'd0;
    localparam logic [3:0] OP_RD = 4'd1;
    localparam int NV = 34;

    // fields: [31:28] requirement, [27:24] op, [23:16] addr, [15:8] wdata, [7:0] expected read
    localparam logic [31:0] VEC [NV] = '{
        {4'd1,  OP_RD, CA, 8'h00, 8'h00},  // R1 reset value
        {4'd2,  OP_WR, CA, 8'h13, 8'h00},  // R2 locked write
        {4'd2,  OP_RD, CA, 8'h00, 8'h00},  // R2
        {4'd5,  OP_WR, KA, 8'h59, 8'h00},  // R5 lone second key
        {4'd5,  OP_WR, CA, 8'h13, 8'h00},  // R5
        {4'd5,  OP_RD, CA, 8'h00, 8'h00},  // R5
        {4'd3,  OP_WR, KA, 8'h87, 8'h00},  // R3 open sequence
        {4'd3,  OP_WR, KA, 8'h59, 8'h00},  // R3
        {4'd3,  OP_WR, CA, 8'h13, 8'h00},  // R3
        {4'd3,  OP_RD, CA, 8'h00, 8'h13},  // R3
        {4'd3,  OP_WR, CA, 8'h1F, 8'h00},  // R3
        {4'd3,  OP_RD, CA, 8'h00, 8'h1F},  // R3
        {4'd4,  OP_WR, KA, 8'h00, 8'h00},  // R4 relock
        {4'd4,  OP_WR, CA, 8'h02, 8'h00},  // R4
        {4'd4,  OP_RD, CA, 8'h00, 8'h1F},  // R4
        {4'd6,  OP_WR, KA, 8'h87, 8'h00},  // R6 foreign write between keys
        {4'd6,  OP_WR, UA, 8'h55, 8'h00},  // R6
        {4'd6,  OP_WR, KA, 8'h59, 8'h00},  // R6
        {4'd6,  OP_WR, CA, 8'h05, 8'h00},  // R6
        {4'd6,  OP_RD, CA, 8'h00, 8'h05},  // R6
        {4'd6,  OP_WR, KA, 8'h87, 8'h00},  // R6 repeated first key
        {4'd6,  OP_WR, KA, 8'h87, 8'h00},  // R6
        {4'd6,  OP_WR, KA, 8'h59, 8'h00},  // R6
        {4'd6,  OP_WR, CA, 8'h11, 8'h00},  // R6
        {4'd6,  OP_RD, CA, 8'h00, 8'h11},  // R6
        {4'd12, OP_WR, CA, 8'h81, 8'h00},  // R12 bit7 without bit1
        {4'd12, OP_RD, CA, 8'h00, 8'h01},  // R12
        {4'd4,  OP_WR, KA, 8'h87, 8'h00},  // R4 stray key breaks sequence
        {4'd4,  OP_WR, KA, 8'h33, 8'h00},  // R4
        {4'd4,  OP_WR, KA, 8'h59, 8'h00},  // R4
        {4'd4,  OP_WR, CA, 8'h10, 8'h00},  // R4
        {4'd4,  OP_RD, CA, 8'h00, 8'h01},  // R4
        {4'd11, OP_RD, KA, 8'h00, 8'h00},  // R11 key address reads 0
        {4'd11, OP_RD, UA, 8'h00, 8'h00}   // R11 unmapped address
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       boot_strap = 1'b0;
    logic       aux_ram_en, prog_en, boot_sel, sw_rst_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cfg_key_guard u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .boot_strap(boot_strap),
        .aux_ram_en(aux_ram_en), .prog_en(prog_en), .boot_sel(boot_sel),
        .sw_rst_pulse(sw_rst_pulse)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic outs(input string tag, input logic [3:0] exp);
        chk(tag, {4'h0, aux_ram_en, prog_en, boot_sel, sw_rst_pulse}, {4'h0, exp});
    endtask

    task automatic unlock();
        wr(KA, 8'h87);
        wr(KA, 8'h59);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        outs("R1 outputs after reset", 4'b0000);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][27:24] == OP_WR) begin
                wr(VEC[i][23:16], VEC[i][15:8]);
            end else begin
                rd($sformatf("R%0d vector %0d", VEC[i][31:28], i), VEC[i][23:16], VEC[i][7:0]);
            end
        end

        // R7 derived outputs
        unlock();
        wr(CA, 8'h13);
        outs("R7 outputs for 0x13", 4'b1110);
        wr(CA, 8'h10);
        outs("R7 outputs for 0x10", 4'b1000);

        // R10 strap view and unimplemented bits
        wr(CA, 8'h7F);
        rd("R10 strap low", CA, 8'h1F);
        @(negedge clk);
        boot_strap = 1'b1;
        rd("R10 strap high", CA, 8'h9F);

        // R8 software reset pulse
        wr(CA, 8'h83);
        outs("R8 pulse raised, data not stored", 4'b1111);
        rd("R8 register kept", CA, 8'h9F);
        @(negedge clk);
        outs("R8 pulse single cycle / R9 cleared", 4'b0000);
        rd("R9 register cleared", CA, 8'h80);
        wr(CA, 8'h13);
        rd("R9 relocked", CA, 8'h80);
        wr(CA, 8'h83);
        outs("R8 no pulse while locked", 4'b0000);

        // R1 reset in the middle of a run
        unlock();
        wr(CA, 8'h13);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        outs("R1 outputs after mid-run reset", 4'b0000);
        rd("R1 register after mid-run reset", CA, 8'h80);
        wr(CA, 8'h13);
        rd("R1 guard closed after reset", CA, 8'h80);

        finish_run();
    end

endmodule